// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressed Word RAM

This block is a synchronous on-chip RAM in which every address names one 8-bit location. A requester issues one access per cycle: either a single byte or a full 32-bit word, read or write. For word accesses, a mode input chooses how the four bytes of the word are laid out across four consecutive addresses. In big-endian placement the most significant byte sits at the lowest address. In little-endian placement the least significant byte sits there. The same stored bytes can therefore be read back as different words, depending on the mode in force when the read is issued.

Storage is split into four byte-wide banks, one for each value of the low two address bits. An aligned word access touches all four banks in one cycle, and a lane-steering stage scatters write bytes into the banks and gathers read bytes out of them. A word request whose address is not a multiple of four is refused: memory is left alone and an error pulse is returned instead of data. A small controller captures each request into address and mode registers and walks a four-state machine. The states are IDLE, RD_RESP, WR_ACK and FAULT. From any state the next state is picked by the request on the current cycle:
- an access-free cycle leads to IDLE;
- a valid read leads to RD_RESP;
- a valid write leads to WR_ACK;
- a misaligned word request leads to FAULT.

Top module: `endian_byte_ram`

## Requirements
- R1: A byte write (size input 0) stores bits 7:0 of the write data at exactly the addressed location; the three other bytes of the same aligned group are unchanged.
- R2: With the mode input at 1 (big-endian), a word write (size input 1) of value W at aligned address a stores W[31:24] at a, W[23:16] at a+1, W[15:8] at a+2 and W[7:0] at a+3.
- R3: With the mode input at 0 (little-endian), a word write of W at aligned address a stores W[7:0] at a, W[15:8] at a+1, W[23:16] at a+2 and W[31:24] at a+3.
- R4: A word read at aligned address a assembles the four stored bytes under the mode present on the request cycle, using the same byte placement as R2 and R3.
- R5: A request with the write enable low never changes memory, whatever the write data bus carries.
- R6: A word request whose address has bits 1:0 not equal to 00 raises the error output for exactly the next cycle. It gives no read-valid and leaves memory unchanged, even with the write enable high.
- R7: The read-valid output rises in the cycle after a read request and only then. The read-data output is zero whenever read-valid is low.
- R8: A byte read returns the stored byte in bits 7:0 of the read data, with bits 31:8 zero.
- R9: Changing the mode input does not alter stored bytes; only later word accesses are assembled differently.
- R10: While reset is held and right after it, read-valid and error are low and read data is zero.
- R11: Requests may be issued on consecutive cycles; each produces its own response one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = 32-bit word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data; byte writes use bits 7:0 |
| big_endian | input | 1 | 1 = big-endian word placement, 0 = little-endian |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 32 | Read data, zero when rd_valid is low |
| err | output | 1 | Misaligned word request refused (one cycle after it) |

## Verification
A wrong bank steering or a lost lane in the controller shows up as permuted or stale bytes. These appear on the first word or byte read that touches the affected group, one cycle after that read is issued. A wrong state in the controller shows up on the next cycle's response flags: a stray read-valid, an error with no misaligned request, or data leaking onto the read bus while read-valid is low. A misaligned write that leaks into memory stays silent until a later aligned read of that group. Every such write is therefore followed by a read-back of the same bytes under both modes.

// File: rtl/erb_pkg.sv
package erb_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_RESP = 2'd1,
        ST_WR_ACK  = 2'd2,
        ST_FAULT   = 2'd3
    } erb_state_t;

    typedef logic [LANES-1:0][BYTE_W-1:0] lane_bytes_t;

endpackage

// File: rtl/erb_bank.sv
// One byte-wide storage bank: synchronous write, registered read.
module erb_bank #(
    parameter int ROWS  = 256,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic [ROW_W-1:0] row,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wbyte,
    output logic [7:0]       rbyte
);

    logic [7:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[row] <= wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rbyte <= cells[row];
        end
    end

endmodule

// File: rtl/erb_lane_steer.sv
// Scatters write bytes into banks and gathers read bytes out of them.
module erb_lane_steer
    import erb_pkg::*;
(
    input  logic              wr_big,
    input  logic              wr_word,
    input  logic [WORD_W-1:0] wdata,
    output lane_bytes_t       bank_wbytes,
    input  logic              rd_big,
    input  logic              rd_word,
    input  logic [1:0]        rd_off,
    input  lane_bytes_t       bank_rbytes,
    output logic [WORD_W-1:0] gathered
);

    logic [WORD_W-1:0] word_be;
    logic [WORD_W-1:0] word_le;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            if (!wr_word) begin
                bank_wbytes[k] = wdata[BYTE_W-1:0];
            end else if (wr_big) begin
                bank_wbytes[k] = wdata[BYTE_W*(LANES-1-k) +: BYTE_W];
            end else begin
                bank_wbytes[k] = wdata[BYTE_W*k +: BYTE_W];
            end
        end
        assign word_be[BYTE_W*(LANES-1-k) +: BYTE_W] = bank_rbytes[k];
        assign word_le[BYTE_W*k +: BYTE_W]           = bank_rbytes[k];
    end

    always_comb begin
        if (!rd_word) begin
            gathered = {{(WORD_W-BYTE_W){1'b0}}, bank_rbytes[rd_off]};
        end else if (rd_big) begin
            gathered = word_be;
        end else begin
            gathered = word_le;
        end
    end

endmodule

// File: rtl/erb_ctrl.sv
// Request capture and response state machine.
module erb_ctrl
    import erb_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic             req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic             big_endian,
    output logic [LANES-1:0] bank_wr_en,
    output logic [LANES-1:0] bank_rd_en,
    output logic             cap_big,
    output logic             cap_word,
    output logic [1:0]       cap_off,
    output logic             rd_valid,
    output logic             err
);

    erb_state_t state_q, state_d;
    logic misaligned;
    logic accept;

    assign misaligned = req_valid && req_size && (req_addr[1:0] != 2'b00);
    assign accept     = req_valid && !misaligned;

    for (genvar k = 0; k < LANES; k++) begin : g_en
        logic hit;
        assign hit           = req_size || (req_addr[1:0] == k[1:0]);
        assign bank_wr_en[k] = accept && req_we && hit;
        assign bank_rd_en[k] = accept && !req_we && hit;
    end

    always_comb begin
        if (misaligned) begin
            state_d = ST_FAULT;
        end else if (accept && req_we) begin
            state_d = ST_WR_ACK;
        end else if (accept) begin
            state_d = ST_RD_RESP;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_big  <= 1'b0;
            cap_word <= 1'b0;
            cap_off  <= 2'b00;
        end else if (accept && !req_we) begin
            cap_big  <= big_endian;
            cap_word <= req_size;
            cap_off  <= req_addr[1:0];
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        err      = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RD_RESP: rd_valid = 1'b1;
            ST_WR_ACK:  ;
            ST_FAULT:   err = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/endian_byte_ram.sv
module endian_byte_ram
    import erb_pkg::*;
#(
    parameter int DEPTH_BYTES = 1024,
    localparam int ADDR_W = $clog2(DEPTH_BYTES),
    localparam int ROWS   = DEPTH_BYTES / LANES,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic              req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              big_endian,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              err
);

    logic [LANES-1:0] bank_wr_en;
    logic [LANES-1:0] bank_rd_en;
    logic             cap_big;
    logic             cap_word;
    logic [1:0]       cap_off;
    lane_bytes_t      wbytes;
    lane_bytes_t      rbytes;
    logic [31:0]      gathered;
    logic [ROW_W-1:0] row;

    assign row = ROW_W'(req_addr >> 2);

    erb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_we     (req_we),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .big_endian (big_endian),
        .bank_wr_en (bank_wr_en),
        .bank_rd_en (bank_rd_en),
        .cap_big    (cap_big),
        .cap_word   (cap_word),
        .cap_off    (cap_off),
        .rd_valid   (rd_valid),
        .err        (err)
    );

    erb_lane_steer u_steer (
        .wr_big      (big_endian),
        .wr_word     (req_size),
        .wdata       (req_wdata),
        .bank_wbytes (wbytes),
        .rd_big      (cap_big),
        .rd_word     (cap_word),
        .rd_off      (cap_off),
        .bank_rbytes (rbytes),
        .gathered    (gathered)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_bank
        erb_bank #(.ROWS(ROWS)) u_bank (
            .clk   (clk),
            .row   (row),
            .wr_en (bank_wr_en[k]),
            .rd_en (bank_rd_en[k]),
            .wbyte (wbytes[k]),
            .rbyte (rbytes[k])
        );
    end

    assign rd_data = rd_valid ? gathered : 32'h0;

endmodule

// File: rtl/erb_checker.sv
module erb_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic              req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              err
);

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_valid && req_size && (req_addr[1:0] != 2'b00)));

    // R6
    err_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size && (req_addr[1:0] != 2'b00)) |=> (err && !rd_valid));

    // R7
    rd_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_we &&
                           !(req_size && (req_addr[1:0] != 2'b00))));

    // R7
    rd_data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == 32'h0));

    // R8
    byte_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(req_size)) |-> (rd_data[31:8] == 24'h0));

    // R11
    resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, err}));

endmodule

bind endian_byte_ram erb_checker #(.ADDR_W(ADDR_W)) u_erb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .err       (err)
);

// File: tb/endian_byte_ram_bench.sv
module endian_byte_ram_bench;

    localparam int DEPTH  = 1024;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_we = 1'b0;
    logic              req_size = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              big_endian = 1'b0;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic              err;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] model [DEPTH];

    int          q_kind [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];

    always #5 clk = ~clk;

    endian_byte_ram #(.DEPTH_BYTES(DEPTH)) u_endian_byte_ram (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .big_endian(big_endian), .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
    );

    task automatic check(string tag, logic v, logic e, logic [31:0] d,
                         logic ev, logic ee, logic [31:0] ed);
        tests++;
        if (v !== ev || e !== ee || d !== ed) begin
            fails++;
            $display("FAIL %s: got valid=%0b err=%0b data=%08h, expected valid=%0b err=%0b data=%08h",
                     tag, v, e, d, ev, ee, ed);
        end
    endtask

    function automatic logic [31:0] model_word(int a, bit be);
        if (be) return {model[a], model[a+1], model[a+2], model[a+3]};
        return {model[a+3], model[a+2], model[a+1], model[a]};
    endfunction

    task automatic drive(bit we, bit word, int a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_size  = word;
        req_addr  = ADDR_W'(a);
        req_wdata = d;
    endtask

    task automatic wr(bit word, int a, logic [31:0] d, string tag);
        drive(1'b1, word, a, d);
        if (word && (a % 4 != 0)) begin
            q_kind.push_back(2); q_data.push_back(32'h0);
        end else begin
            if (!word) model[a] = d[7:0];
            else if (big_endian) begin
                model[a] = d[31:24]; model[a+1] = d[23:16];
                model[a+2] = d[15:8]; model[a+3] = d[7:0];
            end else begin
                model[a] = d[7:0]; model[a+1] = d[15:8];
                model[a+2] = d[23:16]; model[a+3] = d[31:24];
            end
            q_kind.push_back(0); q_data.push_back(32'h0);
        end
        q_tag.push_back(tag);
    endtask

    task automatic rd(bit word, int a, string tag);
        drive(1'b0, word, a, 32'hFFFF_FFFF);
        if (word && (a % 4 != 0)) begin
            q_kind.push_back(2); q_data.push_back(32'h0);
        end else begin
            q_kind.push_back(1);
            q_data.push_back(word ? model_word(a, big_endian) : {24'h0, model[a]});
        end
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_we    = 1'b0;
    endtask

    task automatic set_mode(bit be);
        @(negedge clk);
        req_valid  = 1'b0;
        big_endian = be;
    endtask

    // monitor: pops one expected item per accepted request
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && q_kind.size() > 0) begin
                int k;
                logic [31:0] ed;
                string t;
                k  = q_kind.pop_front();
                ed = q_data.pop_front();
                t  = q_tag.pop_front();
                check(t, rd_valid, err, rd_data, (k == 1), (k == 2), ed);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got running, expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        #2;
        check("R10 reset", rd_valid, err, rd_data, 1'b0, 1'b0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R10 after reset", rd_valid, err, rd_data, 1'b0, 1'b0, 32'h0);

        // clear a working area with byte writes (R1)
        for (int i = 0; i < 32; i++) wr(1'b0, i, 32'h0, "R1 clear");
        idle();

        // R2 big-endian word placement
        set_mode(1'b1);
        wr(1'b1, 8, 32'hA1B2_C3D4, "R2 write");
        for (int i = 0; i < 4; i++) rd(1'b0, 8 + i, "R2 byte read");
        rd(1'b1, 8, "R4 be word read");
        idle();

        // R3 little-endian word placement
        set_mode(1'b0);
        wr(1'b1, 16, 32'hA1B2_C3D4, "R3 write");
        for (int i = 0; i < 4; i++) rd(1'b0, 16 + i, "R3 byte read");
        rd(1'b1, 16, "R4 le word read");

        // R9 stored bytes survive a mode change; R4 regather
        rd(1'b1, 8, "R9 be-stored read le");
        set_mode(1'b1);
        rd(1'b1, 16, "R9 le-stored read be");
        for (int i = 0; i < 4; i++) rd(1'b0, 16 + i, "R9 bytes intact");

        // R1 single byte in a group, neighbours unchanged; R8 zero-extend
        wr(1'b0, 10, 32'h1234_565A, "R1 byte write");
        for (int i = 0; i < 4; i++) rd(1'b0, 8 + i, "R1 R8 neighbours");
        rd(1'b1, 8, "R4 word after byte write");

        // R5 read with write data driven does not write (rd drives FFFFFFFF)
        rd(1'b0, 20, "R5 read with data");
        rd(1'b1, 20, "R5 word unchanged");

        // R6 misaligned word write and read refused
        wr(1'b1, 9, 32'hDEAD_BEEF, "R6 misaligned write");
        rd(1'b1, 14, "R6 misaligned read");
        rd(1'b1, 8, "R6 group 8 unchanged");
        rd(1'b1, 12, "R6 group 12 unchanged");
        set_mode(1'b0);
        rd(1'b1, 8, "R6 group 8 unchanged le");

        // R11 back-to-back mixed traffic
        wr(1'b1, 24, 32'h0102_0304, "R11 write");
        rd(1'b1, 24, "R11 read");
        wr(1'b0, 27, 32'h0000_00EE, "R11 byte write");
        rd(1'b1, 24, "R11 read after byte");
        rd(1'b0, 24, "R11 R8 byte read");
        idle();
        // R7 no response on an idle cycle
        @(posedge clk); #2;
        check("R7 idle quiet", rd_valid, err, rd_data, 1'b0, 1'b0, 32'h0);
        idle();
        idle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule